// File: doc/BRIEF.md
# Interrupt Enable Set Bank

This block holds one enable bit for each of 128 interrupt request lines and applies them as a mask. The enables sit behind a 32-bit word port with a privilege flag. Software turns lines on by writing ones. A zero bit in a write changes nothing, so this port can never turn an enable off. Only writes flagged as privileged are accepted. Reads are allowed at any privilege level and return the current enable state.

Each raw request is ANDed with its enable bit to drive a masked request bus for a downstream prioritizer. The two lowest lines are hardwired on: they can't be switched off, and their requests always pass through. The read path and the masking are combinational. A write is registered and takes effect at the next rising clock edge.

Top module: `irq_en_set_bank`

## Requirements
- R1: After reset, the word at offset 0x30 reads 0x00000003 and the words at 0x34, 0x38 and 0x3C read 0x00000000.
- R2: The four enable words sit at byte offsets 0x30, 0x34, 0x38 and 0x3C. Word k holds lines 32k+31 down to 32k, with line 32k+b in bit b. A privileged write with bit b set enables that line, and the change shows on the read port and on req_o from the next rising clock edge.
- R3: A zero bit in an accepted write leaves the matching enable bit unchanged. No write ever clears an enable.
- R4: A write with priv_i low leaves every enable bit unchanged and signals nothing.
- R5: Bits 1:0 of the word at 0x30 always read as binary 11, whatever is written to them.
- R6: Reads are combinational from addr_i and do not depend on priv_i.
- R7: An access to any address that is not one of the four word-aligned offsets reads 0x00000000. A write to such an address changes no enable bit.
- R8: For every line n, req_o[n] equals req_i[n] AND the enable bit of line n, combinationally.
- R9: req_o[1:0] always follows req_i[1:0], in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| priv_i | input | 1 | Marks the access as privileged |
| addr_i | input | 8 | Byte address of the access |
| wdata_i | input | 32 | Write data; each one bit sets the matching enable |
| rdata_o | output | 32 | Read data for addr_i |
| req_i | input | 128 | Raw request lines |
| req_o | output | 128 | Request lines masked by the enables |

## Verification
Several properties are checked on every cycle by the assertions:
- no enable bit ever falls;
- non-privileged writes and writes to unmapped addresses leave the state unchanged;
- an accepted write always sets every bit it carries;
- unmapped reads return zero;
- no masked request is active on a disabled line;
- the two hardwired lines always pass through.

Some behaviour can only be shown by the bench's scenarios, because it needs an independent model of the state:
- the exact reset contents;
- the mapping from offset to line range;
- misaligned and out-of-range addresses being rejected;
- reads ignoring privilege;
- the full masked bus matching the state that software wrote.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // bits of word k whose line index is below hard_ch are hardwired on
  function automatic word_t hard_mask(int unsigned k, int unsigned hard_ch);
    word_t m;
    m = '0;
    for (int unsigned b = 0; b < WORD_W; b++) begin
      if (k * WORD_W + b < hard_ch) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_en_decode.sv
module irq_en_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned BASE_OFS  = 'h30
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_WORDS-1:0] sel_o,
  output logic                 hit_o
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] WordAddr = ADDR_W'(BASE_OFS + 4 * k);
    assign sel_o[k] = (addr_i == WordAddr);
  end

  assign hit_o = |sel_o;

  // R7: at most one word is selected for any address
  always_comb begin
    a_r7_sel_onehot: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/irq_en_word.sv
module irq_en_word #(
  parameter int unsigned         W     = 32,
  parameter logic [W-1:0]        FIXED = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (FIXED[b]) begin : g_hard
      assign q_o[b] = 1'b1;
    end else begin : g_reg
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    q <= 1'b0;
        else if (set_i && wdata_i[b])   q <= 1'b1;
      end
      assign q_o[b] = q;
    end
  end

  a_r3_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(q_o)) == $past(q_o)));

  a_r2_set_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/irq_en_mask.sv
module irq_en_mask #(
  parameter int unsigned NUM_CH  = 128,
  parameter int unsigned HARD_CH = 2
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] req_o
);
  assign req_o = req_i & en_i;

  always_comb begin
    a_r8_no_masked_leak: assert ((req_o & ~en_i) == '0);
  end
endmodule

// File: rtl/irq_en_set_bank.sv
module irq_en_set_bank
  import irq_en_pkg::*;
#(
  parameter int unsigned NUM_CH   = 128,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE_OFS = 'h30,
  parameter int unsigned HARD_CH  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                priv_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic [NUM_CH-1:0]   req_i,
  output logic [NUM_CH-1:0]   req_o
);
  localparam int unsigned NumWords = (NUM_CH + WORD_W - 1) / WORD_W;

  logic [NumWords-1:0] sel;
  logic                hit;
  logic                wr_ok;
  word_t               words [NumWords];
  logic [NumWords*WORD_W-1:0] en_flat;

  irq_en_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NumWords),
    .BASE_OFS (BASE_OFS)
  ) i_decode (
    .addr_i(addr_i),
    .sel_o (sel),
    .hit_o (hit)
  );

  assign wr_ok = wr_en_i & priv_i;

  for (genvar k = 0; k < NumWords; k++) begin : g_word
    irq_en_word #(
      .W    (WORD_W),
      .FIXED(hard_mask(k, HARD_CH))
    ) i_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_ok & sel[k]),
      .wdata_i(wdata_i),
      .q_o    (words[k])
    );
    assign en_flat[k*WORD_W +: WORD_W] = words[k];
  end

  always_comb begin
    rdata_o = '0;
    for (int unsigned k = 0; k < NumWords; k++) begin
      if (sel[k]) rdata_o = words[k];
    end
  end

  irq_en_mask #(
    .NUM_CH (NUM_CH),
    .HARD_CH(HARD_CH)
  ) i_mask (
    .req_i(req_i),
    .en_i (en_flat[NUM_CH-1:0]),
    .req_o(req_o)
  );

  a_r4_nonpriv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> $stable(en_flat));

  a_r7_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(en_flat));

  a_r7_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));

  a_r5_low_bits_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(BASE_OFS)) |-> (rdata_o[1:0] == 2'b11));

  a_r9_hard_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[1:0] == req_i[1:0]);
endmodule

// File: tb/test_irq_en_set_bank.sv
`timescale 1ns/1ps
module test_irq_en_set_bank;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         priv_i = 1'b0;
  logic [7:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] req_i = '0;
  logic [127:0] req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit model [128];

  always #2.5 clk_i = ~clk_i;

  irq_en_set_bank i_irq_en_set_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .priv_i(priv_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .req_i(req_i), .req_o(req_o)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    logic [31:0] r;
    int idx;
    r = '0;
    if (a >= 8'h30 && a <= 8'h3C && a[1:0] == 2'b00) begin
      idx = (int'(a) - 'h30) / 4;
      for (int b = 0; b < 32; b++) r[b] = model[idx*32+b];
    end
    return r;
  endfunction

  function automatic logic [127:0] exp_req();
    logic [127:0] r;
    for (int n = 0; n < 128; n++) r[n] = req_i[n] & model[n];
    return r;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check128(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < 128; n++) model[n] = (n < 2);
  endtask

  // one cycle: drive, compare combinational outputs, clock, update model
  task automatic step(string tag, logic wr, logic pv, logic [7:0] a,
                      logic [31:0] wd, logic [127:0] rq);
    int idx;
    wr_en_i = wr; priv_i = pv; addr_i = a; wdata_i = wd; req_i = rq;
    #1;
    check32(tag, rdata_o, exp_read(a));
    check128({tag, "/R8"}, req_o, exp_req());
    @(posedge clk_i);
    if (wr && pv && a >= 8'h30 && a <= 8'h3C && a[1:0] == 2'b00) begin
      idx = (int'(a) - 'h30) / 4;
      for (int b = 0; b < 32; b++) if (wd[b]) model[idx*32+b] = 1'b1;
    end
    @(negedge clk_i);
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 4; k++) step(tag, 1'b0, 1'b0, 8'(8'h30 + 4*k), '0, '1);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_all("R1_reset");
    step("R9_low_pass", 1'b0, 1'b0, 8'h30, '0, 128'h3);
    step("R2_set_w1", 1'b1, 1'b1, 8'h34, 32'hFFFF_FFFF, '1);
    step("R2_readback", 1'b0, 1'b0, 8'h34, '0, '1);
    step("R3_zero_write", 1'b1, 1'b1, 8'h34, 32'h0, '1);
    step("R3_no_clear", 1'b0, 1'b0, 8'h34, '0, '1);
    step("R4_nonpriv", 1'b1, 1'b0, 8'h38, 32'hFFFF_FFFF, '1);
    step("R4_held", 1'b0, 1'b1, 8'h38, '0, '1);
    step("R6_read_priv", 1'b0, 1'b1, 8'h34, '0, '0);
    step("R6_read_user", 1'b0, 1'b0, 8'h34, '0, '0);
    step("R5_write_low", 1'b1, 1'b1, 8'h30, 32'h0000_0000, '1);
    step("R5_low_on", 1'b0, 1'b0, 8'h30, '0, '1);
    step("R2_word3", 1'b1, 1'b1, 8'h3C, 32'h8000_0001, '1);
    step("R7_write_out", 1'b1, 1'b1, 8'h40, 32'hFFFF_FFFF, '1);
    step("R7_write_mis", 1'b1, 1'b1, 8'h31, 32'hFFFF_FFFF, '1);
    step("R7_read_mis", 1'b0, 1'b0, 8'h32, '0, '1);
    step("R7_read_low", 1'b0, 1'b0, 8'h2C, '0, '1);
    read_all("R7_state");
    step("R9_low_user", 1'b0, 1'b0, 8'h00, '0, 128'h2);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(8'h30 + 4 * ($urandom % 4));
      step("R8_random", 1'($urandom), 1'($urandom),
           a, $urandom & $urandom & $urandom,
           {$urandom, $urandom, $urandom, $urandom});
    end
    read_all("R2_final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule